// File: doc/BRIEF.md
# Rank-Indexed Mask Expander

This block turns a two-level significance mask into one flat mask. A wide coarse mask marks the positions of interest. A narrower fine mask then qualifies those marked positions. Fine bit j does not refer to position j. It refers to the j-th marked position of the coarse mask, counted from the left. The expander finds, for every coarse position, how many marked positions sit to its left. That running count is the position's rank. A set coarse bit passes through only when the fine bit at its rank is also set.

The datapath is combinational and holds no state, so the flat mask is ready in the same cycle that the two masks are presented. A consumer that reads data words after a header can therefore use the flat mask from the first data word onward. Both widths are parameters. The defaults are 128 coarse bits and 48 fine bits.

Top module: `rmx_expand`

## Requirements
- R1: An output bit can be 1 only where the coarse mask bit at the same position is 1.
- R2: Bit position CW-1 is the leftmost. Output bit i equals coarse bit i AND fine bit (FW-1-r), where r is the number of set coarse bits at positions above i. Fine-mask index 0 is the fine mask's MSB, fine[FW-1].
- R3: For coarse bits [31:0] = 0x38220812 with all higher coarse bits 0, and fine = 0x44 in bits [FW-1:FW-8] with all other fine bits 0, the output is 0x10000800.
- R4: A fine mask with a single 1 at index k selects only the k-th set coarse bit (k counted from 0). With an all-ones coarse mask, that is output bit CW-1-k. No more than one output bit is ever set in this case.
- R5: Fine bits whose index is equal to or greater than the number of set coarse bits have no effect on the output.
- R6: An all-zero coarse mask gives an all-zero output.
- R7: An all-zero fine mask gives an all-zero output.
- R8: The output is a pure function of the present inputs. It is valid in the same cycle that the inputs are applied, and no earlier input affects it.
- R9: The number of set output bits never exceeds the number of set fine bits.
- R10: When the fine mask is all ones and the coarse mask has at most FW set bits, the output equals the coarse mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| coarse_i | input | CW | Coarse mask; bit CW-1 is the leftmost position |
| fine_i | input | FW | Fine mask; bit FW-1 qualifies the first set coarse bit |
| expanded_o | output | CW | Flat mask: coarse bits whose rank-selected fine bit is set |

## Verification
Every result is due in the same cycle as its stimulus. The driver applies both masks on a falling clock edge and queues the expected flat mask at that time. The monitor takes that entry off the queue on the next rising edge, half a cycle later, and compares it with the output. Because each vector is compared before the next one is applied, any dependence on an earlier vector shows up as a miscompare (R8).

// File: rtl/rmx_pkg.sv
package rmx_pkg;

  // Number of set bits in a vector of up to 128 bits (zero-extended).
  function automatic int unsigned rmx_popcount(input logic [127:0] v);
    int unsigned n;
    n = 0;
    for (int b = 0; b < 128; b++) begin
      n = n + int'(v[b]);
    end
    return n;
  endfunction

endpackage

// File: rtl/rmx_prefix_count.sv
// Running count of set coarse bits strictly to the left of each position.
module rmx_prefix_count #(
  parameter int CW   = 128,
  parameter int CNTW = $clog2(CW) + 1
) (
  input  logic [CW-1:0]           coarse_i,
  output logic [CW-1:0][CNTW-1:0] rank_o
);

  assign rank_o[CW-1] = '0;

  for (genvar i = CW - 2; i >= 0; i--) begin : g_chain
    assign rank_o[i] = rank_o[i+1] + CNTW'(coarse_i[i+1]);
  end

endmodule

// File: rtl/rmx_bit_select.sv
// One output position: gate the coarse bit with the fine bit its rank points at.
module rmx_bit_select #(
  parameter int CNTW = 8,
  localparam int NW = 1 << CNTW
) (
  input  logic            coarse_bit_i,
  input  logic [CNTW-1:0] rank_i,
  input  logic [NW-1:0]   fine_by_rank_i,
  output logic            out_bit_o
);

  logic picked;

  always_comb begin
    picked    = fine_by_rank_i[rank_i];
    out_bit_o = coarse_bit_i & picked;
  end

endmodule

// File: rtl/rmx_expand.sv
module rmx_expand #(
  parameter int CW = 128,
  parameter int FW = 48
) (
  input  logic [CW-1:0] coarse_i,
  input  logic [FW-1:0] fine_i,
  output logic [CW-1:0] expanded_o
);

  localparam int CNTW = $clog2(CW) + 1;
  localparam int NW   = 1 << CNTW;

  logic [CW-1:0][CNTW-1:0] rank;
  logic [NW-1:0]           fine_by_rank;

  // Reorder the fine mask so that entry r holds the bit for rank r.
  // Ranks at or above FW read zero.
  for (genvar j = 0; j < NW; j++) begin : g_reorder
    if (j < FW) begin : g_live
      assign fine_by_rank[j] = fine_i[FW-1-j];
    end else begin : g_pad
      assign fine_by_rank[j] = 1'b0;
    end
  end

  rmx_prefix_count #(
    .CW   (CW),
    .CNTW (CNTW)
  ) u_prefix (
    .coarse_i (coarse_i),
    .rank_o   (rank)
  );

  for (genvar i = 0; i < CW; i++) begin : g_sel
    rmx_bit_select #(
      .CNTW (CNTW)
    ) u_sel (
      .coarse_bit_i   (coarse_i[i]),
      .rank_i         (rank[i]),
      .fine_by_rank_i (fine_by_rank),
      .out_bit_o      (expanded_o[i])
    );
  end

endmodule

// File: rtl/rmx_expand_chk.sv
module rmx_expand_chk #(
  parameter int CW = 128,
  parameter int FW = 48
) (
  input logic [CW-1:0] coarse_i,
  input logic [FW-1:0] fine_i,
  input logic [CW-1:0] expanded_o
);
  import rmx_pkg::*;

  int unsigned n_coarse, n_fine, n_out;

  always_comb begin
    n_coarse = rmx_popcount(128'(coarse_i));
    n_fine   = rmx_popcount(128'(fine_i));
    n_out    = rmx_popcount(128'(expanded_o));

    p_subset_r1: assert ((expanded_o & ~coarse_i) == '0)
      else $error("R1: output bit outside coarse mask");

    if ($onehot0(fine_i)) begin
      p_single_r4: assert ($onehot0(expanded_o))
        else $error("R4: single fine bit produced several outputs");
    end

    if (coarse_i == '0) begin
      p_zero_coarse_r6: assert (expanded_o == '0)
        else $error("R6: nonzero output with empty coarse mask");
    end

    if (fine_i == '0) begin
      p_zero_fine_r7: assert (expanded_o == '0)
        else $error("R7: nonzero output with empty fine mask");
    end

    p_count_r9: assert (n_out <= n_fine)
      else $error("R9: more output bits than fine bits");

    if (fine_i == '1 && n_coarse <= FW) begin
      p_pass_r10: assert (expanded_o == coarse_i)
        else $error("R10: full fine mask did not pass coarse mask");
    end
  end

endmodule

bind rmx_expand rmx_expand_chk #(
  .CW (CW),
  .FW (FW)
) u_chk (
  .coarse_i   (coarse_i),
  .fine_i     (fine_i),
  .expanded_o (expanded_o)
);

// File: tb/tb_rmx_expand.sv
module tb_rmx_expand;
  localparam int CW = 128;
  localparam int FW = 48;

  typedef struct {
    logic [CW-1:0] exp;
    string         tag;
  } item_t;

  logic          clk;
  logic [CW-1:0] coarse;
  logic [FW-1:0] fine;
  logic [CW-1:0] expanded;

  item_t queue_q[$];
  int    vectors = 0;
  int    fails   = 0;
  int    cycles  = 0;
  bit    done    = 0;

  rmx_expand #(.CW(CW), .FW(FW)) dut (
    .coarse_i   (coarse),
    .fine_i     (fine),
    .expanded_o (expanded)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Reference model: walk bits left to right, keeping a rank counter.
  function automatic logic [CW-1:0] ref_model(input logic [CW-1:0] c, input logic [FW-1:0] f);
    logic [CW-1:0] r;
    int            rank;
    r    = '0;
    rank = 0;
    for (int i = CW - 1; i >= 0; i--) begin
      if (c[i]) begin
        if (rank < FW && f[FW-1-rank]) r[i] = 1'b1;
        rank++;
      end
    end
    return r;
  endfunction

  task automatic drive(input logic [CW-1:0] c, input logic [FW-1:0] f,
                       input logic [CW-1:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    coarse = c;
    fine   = f;
    it.exp = exp;
    it.tag = tag;
    queue_q.push_back(it);
  endtask

  task automatic drive_ref(input logic [CW-1:0] c, input logic [FW-1:0] f, input string tag);
    drive(c, f, ref_model(c, f), tag);
  endtask

  // Monitor: result is due half a cycle after the inputs change.
  always @(posedge clk) begin
    if (queue_q.size() > 0) begin
      item_t it;
      it = queue_q.pop_front();
      vectors++;
      if (expanded !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.tag, expanded, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  function automatic logic [CW-1:0] rnd_cw();
    logic [CW-1:0] v;
    for (int w = 0; w < CW / 32; w++) v[w*32 +: 32] = $urandom();
    return v;
  endfunction

  initial begin
    logic [CW-1:0] c;
    logic [FW-1:0] f;
    coarse = '0;
    fine   = '0;

    // Idle state: both masks empty
    drive('0, '0, '0, "R6 idle");

    // R3: worked example
    c = '0; c[31:0] = 32'h3822_0812;
    f = '0; f[FW-1 -: 8] = 8'h44;
    drive(c, f, {96'h0, 32'h1000_0800}, "R3 example");

    // R2: fine MSB qualifies first set coarse bit only
    f = '0; f[FW-1] = 1'b1;
    drive(c, f, {96'h0, 32'h2000_0000}, "R2 msb-rank0");

    // R4: single fine bit with all-ones coarse
    for (int k = 0; k < 12; k++) begin
      logic [CW-1:0] e;
      f = '0; f[FW-1-k] = 1'b1;
      e = '0; e[CW-1-k] = 1'b1;
      drive('1, f, e, "R4 single");
    end
    f = '0; f[FW-1] = 1'b1;
    drive('1, f, {1'b1, {(CW-1){1'b0}}}, "R4 k0");
    f = '0; f[0] = 1'b1;
    drive('1, f, {{(FW-1){1'b0}}, 1'b1, {(CW-FW){1'b0}}}, "R4 klast");

    // R5: only ranks beyond the coarse count are set
    c = '0; c[100] = 1'b1; c[40] = 1'b1; c[3] = 1'b1;
    f = '1; f[FW-1 -: 3] = 3'b000;
    drive(c, f, '0, "R5 beyond-count");
    f = '0; f[FW-2] = 1'b1; f[FW-10] = 1'b1;
    drive(c, f, {{(CW-41){1'b0}}, 1'b1, 40'h0}, "R5 mixed");

    // R6 / R7
    drive('0, '1, '0, "R6 zero-coarse");
    drive('1, '0, '0, "R7 zero-fine");

    // R10: full fine mask passes sparse coarse masks
    c = {32'h8000_0001, 32'h0, 32'h00F0_0000, 32'h1111_1111};
    drive(c, '1, c, "R10 pass");
    drive('1, '1, {{FW{1'b1}}, {(CW-FW){1'b0}}}, "R10 saturate");

    // R2 / R9: mixed random patterns against the reference model
    for (int n = 0; n < 300; n++) begin
      c = rnd_cw();
      if (n % 3 == 1) c = c & rnd_cw() & rnd_cw();
      f = {$urandom(), $urandom()};
      drive_ref(c, f, "R2 random");
    end

    // R8: alternating vectors; each result must depend only on its own inputs
    for (int n = 0; n < 20; n++) begin
      c = (n % 2 == 0) ? '1 : '0;
      f = (n % 2 == 0) ? {FW{1'b1}} : {FW{1'b0}};
      drive_ref(c, f, "R8 toggle");
    end

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule